// File: doc/BRIEF.md
# Timed-Window Beat Counter

This block measures a beat rate by counting event pulses inside a fixed window of reference ticks. A single-cycle start pulse clears both counters and opens the window. A two-decade BCD timebase counts rising edges of the reference tick. When its tens digit reaches the window length in tens (three by default, so thirty ticks), the window closes. Event pulses are counted on their falling edges by a second two-decade BCD counter, but only while the window is open.

The same closed-window decode that stops the event counter also stops the timebase. Once the window shuts, the whole block freezes and the two result digits stay on the outputs until the next start. The reference tick and the event input may be asynchronous: each passes through its own synchronizer, and both counters run on one system clock. After reset the block sits in the frozen state showing zero, waiting for a start.

Top module: `beat_window_counter`

## Requirements
- R1: After reset, window_open is 0 and both result digits are 0.
- R2: A start pulse sampled high on a clock edge makes both digits 0 and window_open 1 from that edge on.
- R3: The window stays open through 29 counted reference-tick rising edges after a start and closes on the 30th (WINDOW_TENS × 10).
- R4: While the window is open, each falling edge of event_in adds one to the count. A rising edge or a steady level changes nothing. A change shows on the digits SYNC_STAGES+1 clock edges after the input edge.
- R5: Both digits are BCD values from 0 to 9. The units digit steps 9 to 0 and carries one into the tens digit.
- R6: At the 100th event the tens digit wraps from 9 to 0, giving 00. No overflow indication exists.
- R7: While the window is closed, reference ticks and events have no effect, and the digits hold until the next start.
- R8: A start while the window is open restarts the measurement. The digits return to 0 and a full 30 new ticks are needed to close the window.
- R9: An event falling edge detected in the same cycle as the closing tick is still counted. Event edges after that are not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Synchronous one-cycle request to clear and open the window |
| ref_tick | input | 1 | Reference timebase tick, asynchronous, counted on rising edge |
| event_in | input | 1 | Beat pulse input, asynchronous, counted on falling edge |
| evt_units | output | 4 | BCD units digit of the event count |
| evt_tens | output | 4 | BCD tens digit of the event count |
| window_open | output | 1 | High while the measurement window is open |

## Verification
The hardest case to produce from the ports is an event edge that lands in exactly the cycle the thirtieth tick closes the window. The bench brings the window to 29 ticks with the event input held high. On one clock phase it then raises ref_tick and lowers event_in together. Both inputs pass through synchronizers of the same depth, so their edges are detected in the same cycle. The bench expects that final event to be counted and every later event to be ignored.

// File: rtl/beat_window_counter.sv
module beat_window_counter #(
  parameter int SYNC_STAGES = 2,
  parameter int WINDOW_TENS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ref_tick,
  input  logic       event_in,
  output logic [3:0] evt_units,
  output logic [3:0] evt_tens,
  output logic       window_open
);

  localparam int SW = SYNC_STAGES + 1;
  localparam logic [3:0] CLOSE_TENS = 4'(WINDOW_TENS);

  logic [SW-1:0] tick_sync, evt_sync;
  logic [3:0]    tb_units, tb_tens;
  logic          tick_rise, evt_fall, tb_step, ev_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_sync <= '0;
      evt_sync  <= '0;
    end else begin
      tick_sync <= {tick_sync[SW-2:0], ref_tick};
      evt_sync  <= {evt_sync[SW-2:0], event_in};
    end
  end

  assign tick_rise   = tick_sync[SW-2] & ~tick_sync[SW-1];
  assign evt_fall    = ~evt_sync[SW-2] & evt_sync[SW-1];
  assign window_open = (tb_tens != CLOSE_TENS);
  assign tb_step     = window_open & tick_rise;
  assign ev_step     = window_open & evt_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_units <= '0;
      tb_tens  <= CLOSE_TENS;
    end else if (start) begin
      tb_units <= '0;
      tb_tens  <= '0;
    end else if (tb_step) begin
      if (tb_units == 4'd9) begin
        tb_units <= '0;
        tb_tens  <= tb_tens + 4'd1;
      end else begin
        tb_units <= tb_units + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_units <= '0;
      evt_tens  <= '0;
    end else if (start) begin
      evt_units <= '0;
      evt_tens  <= '0;
    end else if (ev_step) begin
      if (evt_units == 4'd9) begin
        evt_units <= '0;
        evt_tens  <= (evt_tens == 4'd9) ? 4'd0 : evt_tens + 4'd1;
      end else begin
        evt_units <= evt_units + 4'd1;
      end
    end
  end

  AST_BCD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_units <= 4'd9 && evt_tens <= 4'd9 && tb_units <= 4'd9); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> window_open && evt_units == 4'd0 && evt_tens == 4'd0); // R2
  AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_open && !start) |=> !window_open && $stable(evt_units) && $stable(evt_tens)); // R7
  AST_TIMEBASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_open && !start) |=> $stable(tb_units)); // R3
  AST_NO_EDGE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !evt_fall) |=> $stable(evt_units) && $stable(evt_tens)); // R4
  AST_UNITS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && ev_step && evt_units == 4'd9) |=> evt_units == 4'd0); // R5

endmodule

// File: tb/beat_window_counter_bench.sv
module beat_window_counter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0, ref_tick = 0, event_in = 0;
  logic [3:0] evt_units, evt_tens;
  logic window_open;
  int checks = 0, fails = 0;
  bit done = 0;

  beat_window_counter u_beat_window_counter (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_tick(ref_tick),
    .event_in(event_in), .evt_units(evt_units), .evt_tens(evt_tens),
    .window_open(window_open)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    start = 1; wait_cyc(1); start = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ref_tick = 1; wait_cyc(3); ref_tick = 0; wait_cyc(4);
    end
  endtask

  task automatic events(input int n);
    for (int i = 0; i < n; i++) begin
      event_in = 1; wait_cyc(3); event_in = 0; wait_cyc(4);
    end
  endtask

  function automatic int count();
    return evt_tens * 10 + evt_units;
  endfunction

  task automatic t_reset();
    check("R1 window_open", window_open, 0);
    check("R1 units", evt_units, 0);
    check("R1 tens", evt_tens, 0);
    events(3);
    check("R7 events ignored before start", count(), 0);
  endtask

  task automatic t_start();
    do_start();
    check("R2 window_open", window_open, 1);
    check("R2 count", count(), 0);
  endtask

  task automatic t_edges();
    do_start();
    events(7);
    check("R4 seven falls", count(), 7);
    event_in = 1; wait_cyc(6);
    check("R4 rising edge ignored", count(), 7);
    event_in = 0; wait_cyc(5);
    check("R4 falling edge counted", count(), 8);
  endtask

  task automatic t_carry();
    do_start();
    events(23);
    check("R5 tens", evt_tens, 2);
    check("R5 units", evt_units, 3);
  endtask

  task automatic t_window();
    do_start();
    ticks(29);
    check("R3 open after 29", window_open, 1);
    events(4);
    ticks(1);
    check("R3 closed after 30", window_open, 0);
    events(5);
    ticks(12);
    check("R7 count held", count(), 4);
    check("R7 stays closed", window_open, 0);
    wait_cyc(50);
    check("R7 hold idle", count(), 4);
  endtask

  task automatic t_coincide();
    do_start();
    ticks(29);
    events(5);
    event_in = 1; wait_cyc(4);
    ref_tick = 1; event_in = 0; wait_cyc(4);
    ref_tick = 0; wait_cyc(4);
    check("R9 coincident event counted", count(), 6);
    check("R9 window closed", window_open, 0);
    events(2);
    check("R9 later events ignored", count(), 6);
  endtask

  task automatic t_wrap();
    do_start();
    events(99);
    check("R6 ninety-nine", count(), 99);
    events(1);
    check("R6 wrap to zero", count(), 0);
    events(5);
    check("R6 after wrap", count(), 5);
  endtask

  task automatic t_restart();
    do_start();
    ticks(5);
    events(8);
    do_start();
    check("R8 count cleared", count(), 0);
    check("R8 open", window_open, 1);
    ticks(29);
    check("R8 timebase cleared", window_open, 1);
    ticks(1);
    check("R8 closes after full window", window_open, 0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(2);
    t_reset();
    t_start();
    t_edges();
    t_carry();
    t_window();
    t_coincide();
    t_wrap();
    t_restart();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule